// File: doc/BRIEF.md
# Descriptor-Chained Single-Channel DMA Engine

This block is one DMA channel. It moves data between one fixed device register address and a run of incrementing memory addresses. The transfer runs in one direction only, and the control block chooses that direction. A transfer can take its parameters straight from four window inputs, a dev address, a memory address, a size word and a link word. It can also start from the link address alone and fetch a chain of four-word descriptors from memory. Descriptor fetches and data moves both go through a single request/acknowledge memory port. Before each element, the engine waits for the device to signal that it is ready.

Every descriptor carries a size word and a link word. The size word holds an element-width code and a byte count. The link word holds two control bits and the address of the next descriptor. The control bits decide whether the chain continues and whether finishing the descriptor raises an interrupt. A descriptor that is malformed ends the chain with an error. Clearing the mode input aborts the channel at any time.

Top module: `dma_chain_engine`

## Requirements
- R1: In chained mode a start reads four words from memory at B, B+4, B+8 and B+12, where B is `win_next_i` with bits [1:0] cleared. The words are taken in the order dev address, memory address, size word, link word. A link word whose bit 1 is set fetches the next descriptor the same way from its own bits [31:2].
- R2: In single mode (`mode_i`=2) the window inputs serve directly as the descriptor, with no fetch. In chained mode (`mode_i`=1) only the address part of `win_next_i` is used, and the dev, memory and size window inputs have no effect.
- R3: Size word bits [13:12] select the element width: code 3 is 1 byte, code 2 is 2 bytes, code 0 is 4 bytes. Bits [11:0] give the byte count. The transfer makes ceil(count/width) element moves. Each move first reads its source and then writes its destination. The memory address advances by the width each element while the dev address stays fixed. Write data is the read data with all bits above the element width cleared. `mem_width_o` gives log2 of the bytes being accessed.
- R4: When `to_dev_i` is 1 at start, each element reads the memory address and writes the dev address. When it is 0, each element reads the dev address and writes the memory address.
- R5: A size word is rejected when its width code is 1, when its count is 0, or when its count is above 0x3FF for the 1- and 2-byte widths or above 0x7FF for the 4-byte width. A rejected size word makes no data access. It pulses `err_o` and `irq_o` together for one cycle, and the engine returns to idle.
- R6: When a descriptor's last element completes, `irq_o` pulses for one cycle if link bit 0 is 1. If link bit 1 is 0 the engine returns to idle.
- R7: `state_o` reports 0 for idle, 1 for descriptor read, 2 for waiting on the device and 3 for memory access. No memory request is made while idle.
- R8: Before each element the engine waits in state 2 until `dev_ready_i` is high. It makes no memory request while waiting.
- R9: A start is acted on only when the engine is idle and `mode_i` is 1 or 2. A start at any other time leaves the transfer and its outputs unchanged.
- R10: If `mode_i` is 0 or 3, `mem_req_o` is low in that same cycle and the engine is idle on the next cycle. No interrupt or error is raised.
- R11: After reset the engine is idle, with no memory request and no interrupt or error pulse.
- R12: A memory request is held, with its address and write flag stable, until `mem_ack_i` is seen. The request is dropped early only by R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 off, 1 chained, 2 single, 3 off |
| to_dev_i | input | 1 | Direction sampled at start: 1 memory to device |
| start_i | input | 1 | Start request |
| win_dev_i | input | 32 | Window: device address |
| win_mem_i | input | 32 | Window: memory address |
| win_size_i | input | 32 | Window: size word |
| win_next_i | input | 32 | Window: link word |
| dev_ready_i | input | 1 | Device ready for next element |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request address |
| mem_wdata_o | output | 32 | Write data, right-aligned |
| mem_width_o | output | 2 | log2 of access bytes |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data, right-aligned |
| state_o | output | 2 | Engine state code |
| irq_o | output | 1 | Completion or error interrupt pulse |
| err_o | output | 1 | Descriptor error pulse |

## Verification
Wrong state inside the block shows up at the memory port within a few cycles. A bad element counter gives the wrong number of writes, or a last write to the wrong address. A direction flag latched wrongly swaps the read and write addresses on the first element, three cycles after start. A wrong link decode gives a missing or extra interrupt pulse, or a fetch from an unexpected base. A disable path that fails to abort keeps `mem_req_o` high in the cycle after the mode is cleared. The bench compares every write address and data value against values it computes from the descriptor. It also counts pulses and probes the state code while it stalls the acknowledge and the ready inputs.

// File: rtl/dce_pkg.sv
package dce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DESC   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_ACCESS = 2'd3
  } dce_state_e;

  localparam logic [1:0] MD_CHAIN  = 2'd1;
  localparam logic [1:0] MD_SINGLE = 2'd2;

  localparam int DESC_WORDS = 4;
  localparam logic [1:0] WLOG_WORD = 2'd2;
endpackage

// File: rtl/dce_desc_check.sv
module dce_desc_check #(
  parameter int CNT_W      = 12,
  parameter int WSEL_LSB   = 12,
  parameter int LIM_NARROW = 'h3FF,
  parameter int LIM_WIDE   = 'h7FF
) (
  input  logic [WSEL_LSB+1:0] size_i,
  output logic                bad_o,
  output logic [1:0]          wlog_o,
  output logic [CNT_W-1:0]    count_o
);
  logic [CNT_W-1:0] limit;
  logic             code_ok;

  always_comb begin
    count_o = size_i[CNT_W-1:0];
    code_ok = 1'b1;
    limit   = CNT_W'(LIM_WIDE);
    wlog_o  = 2'd2;
    case (size_i[WSEL_LSB+1:WSEL_LSB])
      2'd3: begin wlog_o = 2'd0; limit = CNT_W'(LIM_NARROW); end
      2'd2: begin wlog_o = 2'd1; limit = CNT_W'(LIM_NARROW); end
      2'd0: begin wlog_o = 2'd2; limit = CNT_W'(LIM_WIDE);   end
      default: code_ok = 1'b0;
    endcase
    bad_o = !code_ok || (count_o == '0) || (count_o > limit);
  end
endmodule

// File: rtl/dce_beat_tracker.sv
module dce_beat_tracker #(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       wlog_i,
  output logic [AW-1:0]    addr_o,
  output logic             last_o
);
  logic [AW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] step_bytes;

  assign step_bytes = CNT_W'(1) << wlog_i;
  assign last_o     = (rem_q <= step_bytes);
  assign addr_o     = addr_q;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load_i) begin
      addr_d = addr_i;
      rem_d  = count_i;
    end else if (step_i) begin
      addr_d = addr_q + AW'(step_bytes);
      rem_d  = rem_q - step_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i || step_i) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  // R3: a further element is only requested while bytes remain beyond this one
  p_step_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (rem_q > step_bytes));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dce_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int CNT_W      = 12,
  parameter int WSEL_LSB   = 12,
  parameter int LIM_NARROW = 'h3FF,
  parameter int LIM_WIDE   = 'h7FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          to_dev_i,
  input  logic          start_i,
  input  logic [AW-1:0] win_dev_i,
  input  logic [AW-1:0] win_mem_i,
  input  logic [DW-1:0] win_size_i,
  input  logic [AW-1:0] win_next_i,
  input  logic          dev_ready_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [1:0]    mem_width_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [1:0]    state_o,
  output logic          irq_o,
  output logic          err_o
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int SZ_W  = WSEL_LSB + 2;

  dce_state_e       state_q, state_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic [AW-1:0]    base_q, base_d, dev_q, dev_d, mem_q, mem_d, next_q, next_d;
  logic [SZ_W-1:0]  size_q, size_d;
  logic [DW-1:0]    data_q, data_d;
  logic [1:0]       wlog_q, wlog_d;
  logic             to_dev_q, to_dev_d, wr_q, wr_d;
  logic             irq_q, irq_d, err_q, err_d;

  logic             run_ok;
  logic [SZ_W-1:0]  chk_size;
  logic             chk_bad;
  logic [1:0]       chk_wlog;
  logic [CNT_W-1:0] chk_count;
  logic             trk_load, trk_step, trk_last;
  logic [AW-1:0]    trk_addr, ld_mem;
  logic [DW-1:0]    rd_mask;
  logic             unused_size_hi;

  assign unused_size_hi = ^win_size_i[DW-1:SZ_W];
  assign run_ok   = (mode_i == MD_CHAIN) || (mode_i == MD_SINGLE);
  assign chk_size = (state_q == ST_IDLE) ? win_size_i[SZ_W-1:0] : size_q;
  assign ld_mem   = (state_q == ST_IDLE) ? win_mem_i : mem_q;
  assign rd_mask  = ~({DW{1'b1}} << (6'd8 << wlog_q));

  dce_desc_check #(
    .CNT_W(CNT_W), .WSEL_LSB(WSEL_LSB),
    .LIM_NARROW(LIM_NARROW), .LIM_WIDE(LIM_WIDE)
  ) u_check (
    .size_i(chk_size), .bad_o(chk_bad), .wlog_o(chk_wlog), .count_o(chk_count)
  );

  dce_beat_tracker #(.AW(AW), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .load_i(trk_load), .step_i(trk_step),
    .addr_i(ld_mem), .count_i(chk_count), .wlog_i(trk_load ? chk_wlog : wlog_q),
    .addr_o(trk_addr), .last_o(trk_last)
  );

  // memory port drive
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_width_o = WLOG_WORD;
    mem_wdata_o = data_q;
    case (state_q)
      ST_DESC: begin
        mem_req_o  = run_ok;
        mem_addr_o = base_q + AW'({widx_q, 2'b00});
      end
      ST_ACCESS: begin
        mem_req_o   = run_ok;
        mem_we_o    = wr_q;
        mem_width_o = wlog_q;
        mem_addr_o  = (to_dev_q != wr_q) ? trk_addr : dev_q;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_d  = state_q;
    widx_d   = widx_q;
    base_d   = base_q;
    dev_d    = dev_q;
    mem_d    = mem_q;
    size_d   = size_q;
    next_d   = next_q;
    data_d   = data_q;
    wlog_d   = wlog_q;
    to_dev_d = to_dev_q;
    wr_d     = wr_q;
    irq_d    = 1'b0;
    err_d    = 1'b0;
    trk_load = 1'b0;
    trk_step = 1'b0;
    if (!run_ok) begin
      state_d = ST_IDLE;
      wr_d    = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          to_dev_d = to_dev_i;
          next_d   = win_next_i;
          if (mode_i == MD_CHAIN) begin
            base_d  = {win_next_i[AW-1:2], 2'b00};
            widx_d  = '0;
            state_d = ST_DESC;
          end else if (chk_bad) begin
            err_d = 1'b1;
            irq_d = 1'b1;
          end else begin
            dev_d    = win_dev_i;
            wlog_d   = chk_wlog;
            trk_load = 1'b1;
            state_d  = ST_WAIT;
          end
        end
        ST_DESC: if (mem_ack_i) begin
          widx_d = widx_q + 1'b1;
          case (widx_q)
            2'd0: dev_d  = mem_rdata_i[AW-1:0];
            2'd1: mem_d  = mem_rdata_i[AW-1:0];
            2'd2: size_d = mem_rdata_i[SZ_W-1:0];
            default: begin
              next_d = mem_rdata_i[AW-1:0];
              if (chk_bad) begin
                err_d   = 1'b1;
                irq_d   = 1'b1;
                state_d = ST_IDLE;
              end else begin
                wlog_d   = chk_wlog;
                trk_load = 1'b1;
                state_d  = ST_WAIT;
              end
            end
          endcase
        end
        ST_WAIT: if (dev_ready_i) begin
          wr_d    = 1'b0;
          state_d = ST_ACCESS;
        end
        ST_ACCESS: if (mem_ack_i) begin
          if (!wr_q) begin
            data_d = mem_rdata_i & rd_mask;
            wr_d   = 1'b1;
          end else begin
            wr_d = 1'b0;
            if (trk_last) begin
              irq_d = next_q[0];
              if (next_q[1]) begin
                base_d  = {next_q[AW-1:2], 2'b00};
                widx_d  = '0;
                state_d = ST_DESC;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              trk_step = 1'b1;
              state_d  = ST_WAIT;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      widx_q   <= '0;
      base_q   <= '0;
      dev_q    <= '0;
      mem_q    <= '0;
      size_q   <= '0;
      next_q   <= '0;
      data_q   <= '0;
      wlog_q   <= '0;
      to_dev_q <= 1'b0;
      wr_q     <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      widx_q   <= widx_d;
      base_q   <= base_d;
      dev_q    <= dev_d;
      mem_q    <= mem_d;
      size_q   <= size_d;
      next_q   <= next_d;
      data_q   <= data_d;
      wlog_q   <= wlog_d;
      to_dev_q <= to_dev_d;
      wr_q     <= wr_d;
      irq_q    <= irq_d;
      err_q    <= err_d;
    end
  end

  assign state_o = state_q;
  assign irq_o   = irq_q;
  assign err_o   = err_q;

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE) |-> !mem_req_o);
  p_wait_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WAIT) |-> !mem_req_o);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (!mem_req_o || ($stable(mem_addr_o) && $stable(mem_we_o))));
  p_err_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> irq_o);
  p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> ((state_o == ST_IDLE) && !irq_o && !err_o));
endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;
  localparam logic [31:0] DEVA = 32'h0000_4000;
  localparam logic [31:0] MEMB = 32'h0000_8000;
  localparam int NV = 13;
  // {chain, to_dev, wcode[1:0], count[11:0], ctl[1:0], exp_err}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 12'd8,    2'd1, 1'b0},
    {1'b0, 1'b0, 2'd3, 12'd3,    2'd0, 1'b0},
    {1'b0, 1'b1, 2'd2, 12'd5,    2'd1, 1'b0},
    {1'b0, 1'b0, 2'd3, 12'h3FF,  2'd1, 1'b0},
    {1'b0, 1'b1, 2'd3, 12'h400,  2'd1, 1'b1},
    {1'b0, 1'b1, 2'd0, 12'h7FF,  2'd0, 1'b0},
    {1'b0, 1'b0, 2'd0, 12'h800,  2'd1, 1'b1},
    {1'b0, 1'b1, 2'd2, 12'h400,  2'd1, 1'b1},
    {1'b0, 1'b1, 2'd1, 12'd4,    2'd0, 1'b1},
    {1'b0, 1'b0, 2'd0, 12'd0,    2'd0, 1'b1},
    {1'b1, 1'b0, 2'd0, 12'd12,   2'd1, 1'b0},
    {1'b1, 1'b1, 2'd3, 12'd0,    2'd1, 1'b1},
    {1'b1, 1'b1, 2'd2, 12'h3FF,  2'd1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        to_dev_i, start_i, dev_ready_i;
  logic [31:0] win_dev_i, win_mem_i, win_size_i, win_next_i;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [1:0]  mem_width_o, state_o;
  logic        irq_o, err_o;
  logic        ack_en, clr, done;
  logic [31:0] dmem [0:63];
  logic [31:0] log_a [0:1023];
  logic [31:0] log_d [0:1023];
  int n_wr, n_irq, n_err, n_chk, n_fail, cyc;

  always #10 clk = ~clk;

  dma_chain_engine u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .to_dev_i(to_dev_i), .start_i(start_i),
    .win_dev_i(win_dev_i), .win_mem_i(win_mem_i), .win_size_i(win_size_i),
    .win_next_i(win_next_i), .dev_ready_i(dev_ready_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_width_o(mem_width_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .state_o(state_o), .irq_o(irq_o), .err_o(err_o)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w == 1) ? 32'hFF : (w == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign mem_ack_i   = mem_req_o & ack_en;
  assign mem_rdata_i = (mem_addr_o[31:8] == 24'h1) ? dmem[mem_addr_o[7:2]] : pat(mem_addr_o);

  always @(posedge clk) begin
    cyc++;
    if (clr) begin
      n_wr = 0; n_irq = 0; n_err = 0;
    end else begin
      if (mem_req_o && mem_we_o && mem_ack_i) begin
        if (n_wr < 1024) begin
          log_a[n_wr] = mem_addr_o;
          log_d[n_wr] = mem_wdata_o;
        end
        n_wr++;
      end
      if (irq_o) n_irq++;
      if (err_o) n_err++;
    end
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL R11 watchdog: actual %0d cycles expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; step(1); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (state_o != 2'd0 && t < 20000) begin step(1); t++; end
    if (t >= 20000) chk(1'b0, "R7 return to idle", 32'(state_o), 32'd0);
    step(3);
  endtask

  task automatic set_desc(input int idx, input logic [31:0] dv, mm, sz, nx);
    dmem[idx] = dv; dmem[idx+1] = mm; dmem[idx+2] = sz; dmem[idx+3] = nx;
  endtask

  initial begin
    done = 1'b0; cyc = 0; n_chk = 0; n_fail = 0; n_wr = 0; n_irq = 0; n_err = 0;
    rst_n = 1'b0; mode_i = 2'd0; to_dev_i = 1'b0; start_i = 1'b0; dev_ready_i = 1'b1;
    win_dev_i = '0; win_mem_i = '0; win_size_i = '0; win_next_i = '0;
    ack_en = 1'b1; clr = 1'b0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    chk(state_o == 2'd0, "R11 reset state", 32'(state_o), 32'd0);
    chk(!mem_req_o && !irq_o && !err_o, "R11 reset outputs quiet",
        {29'd0, mem_req_o, irq_o, err_o}, 32'd0);

    // table-driven vectors
    for (int i = 0; i < NV; i++) begin
      logic        ch, td, xerr;
      logic [1:0]  wc, ctl;
      logic [11:0] cnt;
      logic [31:0] szw;
      int w, beats, bad_k;
      {ch, td, wc, cnt, ctl, xerr} = VEC[i];
      w = (wc == 2'd3) ? 1 : (wc == 2'd2) ? 2 : 4;
      szw = {18'd0, wc, cnt};
      beats = xerr ? 0 : (int'(cnt) + w - 1) / w;
      clear_logs();
      to_dev_i = td;
      if (ch) begin
        set_desc(0, DEVA, MEMB, szw, {30'd0, ctl});
        win_dev_i = 32'hDEAD_0000; win_mem_i = 32'h0;
        win_size_i = {18'd0, 2'd1, 12'd0}; win_next_i = 32'h0000_0101;
        mode_i = 2'd1;
      end else begin
        win_dev_i = DEVA; win_mem_i = MEMB; win_size_i = szw; win_next_i = {30'd0, ctl};
        mode_i = 2'd2;
      end
      pulse_start();
      wait_idle();
      chk(n_err == int'(xerr), ch ? "R5 R2 error count (chained)" : "R5 error count",
          32'(n_err), 32'(xerr));
      chk(n_irq == (xerr ? 1 : int'(ctl[0])), "R6 R5 interrupt count",
          32'(n_irq), xerr ? 32'd1 : 32'(ctl[0]));
      chk(n_wr == beats, ch ? "R3 R1 R2 element count" : "R3 element count",
          32'(n_wr), 32'(beats));
      bad_k = -1;
      for (int k = 0; k < beats && k < 1024; k++) begin
        logic [31:0] ma, ra, wa, ed;
        ma = MEMB + 32'(k * w);
        ra = td ? ma : DEVA;
        wa = td ? DEVA : ma;
        ed = pat(ra) & wmask(w);
        if (bad_k < 0 && (k >= n_wr || log_a[k] != wa || log_d[k] != ed)) bad_k = k;
      end
      if (bad_k < 0) chk(1'b1, "R3 R4 write stream", 32'd0, 32'd0);
      else chk(1'b0, "R3 R4 write stream data", log_d[bad_k],
               pat(td ? MEMB + 32'(bad_k * w) : DEVA) & wmask(w));
    end

    // R9: start with mode off is ignored
    clear_logs();
    mode_i = 2'd0; win_dev_i = DEVA; win_mem_i = MEMB; win_size_i = 32'd4; win_next_i = 32'd1;
    pulse_start();
    chk(state_o == 2'd0, "R9 start ignored while mode off", 32'(state_o), 32'd0);
    step(3);
    chk(n_wr == 0 && n_irq == 0, "R9 no activity while mode off", 32'(n_wr + n_irq), 32'd0);

    // R8: waiting for device
    clear_logs();
    mode_i = 2'd2; to_dev_i = 1'b1; dev_ready_i = 1'b0;
    win_size_i = 32'd4; win_next_i = 32'd0;
    pulse_start();
    step(2);
    chk(state_o == 2'd2, "R8 R7 waits for device", 32'(state_o), 32'd2);
    chk(!mem_req_o, "R8 no request while waiting", 32'(mem_req_o), 32'd0);
    dev_ready_i = 1'b1;
    wait_idle();
    chk(n_wr == 1, "R8 proceeds after ready", 32'(n_wr), 32'd1);

    // R7/R4: access state with stalled acknowledge
    clear_logs();
    ack_en = 1'b0;
    pulse_start();
    step(1);
    chk(state_o == 2'd3, "R7 access state code", 32'(state_o), 32'd3);
    chk(!mem_we_o && mem_addr_o == MEMB, "R4 first access reads memory", mem_addr_o, MEMB);
    ack_en = 1'b1;
    wait_idle();

    // R1/R12: descriptor read with stalled acknowledge
    clear_logs();
    set_desc(0, DEVA, MEMB, 32'd4, 32'd0);
    ack_en = 1'b0; mode_i = 2'd1; win_next_i = 32'h0000_0102;
    pulse_start();
    chk(state_o == 2'd1, "R7 descriptor read state code", 32'(state_o), 32'd1);
    chk(mem_req_o && !mem_we_o && mem_addr_o == 32'h100, "R1 fetch base", mem_addr_o, 32'h100);
    step(2);
    chk(mem_req_o && mem_addr_o == 32'h100, "R12 request held until ack", mem_addr_o, 32'h100);
    ack_en = 1'b1;
    wait_idle();
    chk(n_wr == 1, "R1 fetched descriptor runs", 32'(n_wr), 32'd1);

    // R9: start while busy is ignored
    clear_logs();
    mode_i = 2'd2; to_dev_i = 1'b0; win_size_i = {18'd0, 2'd3, 12'd20}; win_next_i = 32'd1;
    pulse_start();
    step(10);
    win_size_i = 32'd4;
    pulse_start();
    wait_idle();
    chk(n_wr == 20, "R9 busy start ignored", 32'(n_wr), 32'd20);
    chk(n_irq == 1, "R9 single completion interrupt", 32'(n_irq), 32'd1);

    // R10: disable mid-transfer
    clear_logs();
    win_size_i = 32'h7FF; win_next_i = 32'd1;
    pulse_start();
    step(30);
    mode_i = 2'd0;
    #1;
    chk(!mem_req_o, "R10 request drops same cycle", 32'(mem_req_o), 32'd0);
    step(1);
    chk(state_o == 2'd0, "R10 idle next cycle", 32'(state_o), 32'd0);
    step(3);
    chk(n_irq == 0 && n_err == 0, "R10 no interrupt on abort", 32'(n_irq + n_err), 32'd0);
    chk(n_wr < 512, "R10 transfer cut short", 32'(n_wr), 32'd511);

    // R6/R1: two-descriptor chain, follow with interrupt then last without
    clear_logs();
    set_desc(0, DEVA, MEMB, 32'd8, 32'h0000_0113);
    set_desc(4, DEVA, 32'h0000_9000, {18'd0, 2'd2, 12'd4}, 32'd0);
    mode_i = 2'd1; to_dev_i = 1'b1; win_next_i = 32'h0000_0100;
    pulse_start();
    wait_idle();
    chk(n_wr == 4, "R6 chain follows link", 32'(n_wr), 32'd4);
    chk(n_irq == 1, "R6 interrupt only where requested", 32'(n_irq), 32'd1);
    chk(log_d[2] == (pat(32'h9000) & 32'hFFFF), "R1 second descriptor data", log_d[2],
        pat(32'h9000) & 32'hFFFF);
    chk(log_d[3] == (pat(32'h9002) & 32'hFFFF) && log_a[3] == DEVA, "R3 second descriptor step",
        log_d[3], pat(32'h9002) & 32'hFFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule